// File: doc/BRIEF.md
# Scaled Index Address Adder Unit

This execution unit forms addresses from a base held in an address register and an index held in a data register. It works in two ways. In scaled mode the index is shifted left by zero to three places and then added to the base. In bit-index mode the index is taken as a signed bit offset, divided by eight with sign fill, and added to the base. The low two bits of that sum are then forced to zero, so the result is the address of the 32-bit word that holds the indexed bit. The result goes to a destination address register.

The unit holds sixteen 32-bit address registers and sixteen 32-bit data registers. Operations arrive as a 32-bit instruction word with a one-cycle valid strobe. A separate short-form flag selects a compact scaled variant. That variant takes its register numbers and shift from dedicated inputs and always uses data register 15 as the index. A preload port writes either register file. Two combinational observation ports read the files back. A word that does not decode raises a one-cycle illegal flag and changes nothing.

Top module: `sidx_agu`

## Requirements
- R1: A long-form word with bits [7:0] = 0x01 and bits [27:20] = 0x60 writes A[word[31:28]] = A[word[15:12]] + (D[word[11:8]] << word[17:16]).
- R2: A long-form word with bits [7:0] = 0x01 and bits [27:20] = 0x62 writes A[word[31:28]] = (A[word[15:12]] + (D[word[11:8]] >>> 3)) with result bits [1:0] cleared. The right shift fills with the sign bit, and bits [17:16] have no effect.
- R3: A long-form word whose bits [7:0] are not 0x01, or whose bits [27:20] are neither 0x60 nor 0x62, is illegal.
- R4: With shortForm high, the unit writes A[shortDst] = A[shortBase] + (D[15] << shortShift). instWord is ignored and illegal stays low.
- R5: Every sum wraps modulo 2^32.
- R6: An illegal word raises illegal for exactly the one cycle after its valid strobe and leaves every register unchanged.
- R7: A write happens on the rising edge where instValid is high. With instValid low, no register changes and illegal stays low.
- R8: A written result is visible on the observation port, and as an operand, in the very next cycle.
- R9: A synchronous reset clears every register in both files and clears illegal.
- R10: The preload port writes A[preIdx] or D[preIdx] on the edge. If a preload and an instruction write target the same address register in one cycle, the instruction result is kept.
- R11: Instructions never modify the data register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction strobe, one cycle per operation |
| instWord | input | 32 | Long-form instruction word |
| shortForm | input | 1 | Selects the short scaled variant |
| shortDst | input | 4 | Short form destination address register |
| shortBase | input | 4 | Short form base address register |
| shortShift | input | 2 | Short form left-shift amount |
| preAddrWe | input | 1 | Preload write enable, address file |
| preDataWe | input | 1 | Preload write enable, data file |
| preIdx | input | 4 | Preload register number |
| preValue | input | 32 | Preload value |
| obsAddrIdx | input | 4 | Address file observation index |
| obsAddrVal | output | 32 | Address register contents, combinational |
| obsDataIdx | input | 4 | Data file observation index |
| obsDataVal | output | 32 | Data register contents, combinational |
| illegal | output | 1 | One-cycle flag for an undecodable word |

## Verification
An instruction writeback and a preload can target the same address register on the same edge. The bench provokes this by raising preAddrWe and instValid together with matching register numbers, for both the long and short forms. It then reads the register back through the observation port and expects the computed sum rather than the preload value. A second case pairs the write with a read: an instruction is issued directly after the one that produced its base register, and the chained sum is compared with the bench's own model.

// File: rtl/sidx_pkg.sv
`timescale 1ns/1ps
package sidx_pkg;
  parameter int XLEN     = 32;
  parameter int NREG     = 16;
  parameter int SHW      = 2;
  parameter int BITSHIFT = 3;
  parameter int ALIGNW   = 2;
  localparam int IDXW    = $clog2(NREG);

  localparam logic [7:0] OP_MAIN    = 8'h01;
  localparam logic [7:0 ] SUB_SCALED = 8'h60;
  localparam logic [7:0] SUB_BITIDX = 8'h62;

  typedef logic [IDXW-1:0] regIdx_t;
  typedef logic [XLEN-1:0] word_t;

  typedef struct packed {
    logic            wrEn;
    logic            bitMode;
    logic            badOp;
    regIdx_t         dst;
    regIdx_t         base;
    regIdx_t         idx;
    logic [SHW-1:0]  shamt;
  } ctrlStrobes_t;
endpackage

// File: rtl/sidx_ctrl.sv
`timescale 1ns/1ps
module sidx_ctrl
  import sidx_pkg::*;
(
  input  logic           instValid,
  input  logic [31:0]    instWord,
  input  logic           shortForm,
  input  regIdx_t        shortDst,
  input  regIdx_t        shortBase,
  input  logic [SHW-1:0] shortShift,
  output ctrlStrobes_t   strobes
);
  localparam regIdx_t IMPLICIT_IDX = regIdx_t'(NREG - 1);

  logic       priOk;
  logic       isScaled;
  logic       isBitIdx;
  logic       legal;
  logic [7:0] subOp;

  always_comb begin
    subOp    = instWord[27:20];
    priOk    = (instWord[7:0] == OP_MAIN);
    isScaled = priOk && (subOp == SUB_SCALED);
    isBitIdx = priOk && (subOp == SUB_BITIDX);
    legal    = isScaled || isBitIdx;

    strobes = '0;
    if (shortForm) begin
      strobes.wrEn    = instValid;
      strobes.bitMode = 1'b0;
      strobes.badOp   = 1'b0;
      strobes.dst     = shortDst;
      strobes.base    = shortBase;
      strobes.idx     = IMPLICIT_IDX;
      strobes.shamt   = shortShift;
    end else begin
      strobes.wrEn    = instValid && legal;
      strobes.bitMode = isBitIdx;
      strobes.badOp   = instValid && !legal;
      strobes.dst     = instWord[28 +: IDXW];
      strobes.base    = instWord[12 +: IDXW];
      strobes.idx     = instWord[8 +: IDXW];
      strobes.shamt   = isBitIdx ? '0 : instWord[16 +: SHW];
    end
  end
endmodule

// File: rtl/sidx_dpath.sv
`timescale 1ns/1ps
module sidx_dpath
  import sidx_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t strobes,
  input  logic         preAddrWe,
  input  logic         preDataWe,
  input  regIdx_t      preIdx,
  input  word_t        preValue,
  input  regIdx_t      obsAddrIdx,
  input  regIdx_t      obsDataIdx,
  output word_t        obsAddrVal,
  output word_t        obsDataVal,
  output word_t        wbValue,
  output logic         illegal
);
  localparam word_t ALIGN_MASK = ~word_t'((1 << ALIGNW) - 1);

  word_t aFile [NREG];
  word_t dFile [NREG];

  word_t baseVal;
  word_t idxVal;
  word_t scaledSum;
  word_t bitOffset;
  word_t bitSum;

  always_comb begin
    baseVal    = aFile[strobes.base];
    idxVal     = dFile[strobes.idx];
    scaledSum  = baseVal + (idxVal << strobes.shamt);
    bitOffset  = word_t'($signed(idxVal) >>> BITSHIFT);
    bitSum     = (baseVal + bitOffset) & ALIGN_MASK;
    wbValue    = strobes.bitMode ? bitSum : scaledSum;
    obsAddrVal = aFile[obsAddrIdx];
    obsDataVal = dFile[obsDataIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        aFile[i] <= '0;
        dFile[i] <= '0;
      end
      illegal <= 1'b0;
    end else begin
      if (preAddrWe) aFile[preIdx] <= preValue;
      if (preDataWe) dFile[preIdx] <= preValue;
      if (strobes.wrEn) aFile[strobes.dst] <= wbValue;
      illegal <= strobes.badOp;
    end
  end
endmodule

// File: rtl/sidx_agu.sv
`timescale 1ns/1ps
module sidx_agu
  import sidx_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           instValid,
  input  logic [31:0]    instWord,
  input  logic           shortForm,
  input  logic [3:0]     shortDst,
  input  logic [3:0]     shortBase,
  input  logic [1:0]     shortShift,
  input  logic           preAddrWe,
  input  logic           preDataWe,
  input  logic [3:0]     preIdx,
  input  logic [31:0]    preValue,
  input  logic [3:0]     obsAddrIdx,
  output logic [31:0]    obsAddrVal,
  input  logic [3:0]     obsDataIdx,
  output logic [31:0]    obsDataVal,
  output logic           illegal
);
  ctrlStrobes_t strobes;
  word_t        wbValue;

  sidx_ctrl ctrl_i (
    .instValid (instValid),
    .instWord  (instWord),
    .shortForm (shortForm),
    .shortDst  (shortDst),
    .shortBase (shortBase),
    .shortShift(shortShift),
    .strobes   (strobes)
  );

  sidx_dpath dpath_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .preAddrWe (preAddrWe),
    .preDataWe (preDataWe),
    .preIdx    (preIdx),
    .preValue  (preValue),
    .obsAddrIdx(obsAddrIdx),
    .obsDataIdx(obsDataIdx),
    .obsAddrVal(obsAddrVal),
    .obsDataVal(obsDataVal),
    .wbValue   (wbValue),
    .illegal   (illegal)
  );
endmodule

// File: rtl/sidx_agu_chk.sv
`timescale 1ns/1ps
module sidx_agu_chk
  import sidx_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         instValid,
  input logic         shortForm,
  input ctrlStrobes_t strobes,
  input word_t        wbValue,
  input logic         illegal,
  input logic         preAddrWe,
  input logic         preDataWe,
  input regIdx_t      preIdx,
  input word_t        preValue,
  input regIdx_t      obsAddrIdx,
  input word_t        obsAddrVal,
  input regIdx_t      obsDataIdx,
  input word_t        obsDataVal
);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrEn && strobes.bitMode) |-> (wbValue[ALIGNW-1:0] == '0));

  a_r6_illegal_source: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($past(instValid && !shortForm) && !$past(strobes.wrEn)));

  // R8 and R10: the value computed last cycle is what the file now holds
  a_r8_visible_next: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobes.wrEn) && (obsAddrIdx == $past(strobes.dst)))
      |-> (obsAddrVal == $past(wbValue)));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (obsAddrVal == '0 && obsDataVal == '0 && !illegal));

  a_r11_data_preload_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(preDataWe) && (obsDataIdx == $past(preIdx)))
      |-> (obsDataVal == $past(preValue)));

  a_r10_preload_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(preAddrWe) && !$past(strobes.wrEn) && (obsAddrIdx == $past(preIdx)))
      |-> (obsAddrVal == $past(preValue)));
endmodule

bind sidx_agu sidx_agu_chk chk_i (.*);

// File: tb/sidx_agu_tb_top.sv
`timescale 1ns/1ps
module sidx_agu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        shortForm = 1'b0;
  logic [3:0]  shortDst = '0;
  logic [3:0]  shortBase = '0;
  logic [1:0]  shortShift = '0;
  logic        preAddrWe = 1'b0;
  logic        preDataWe = 1'b0;
  logic [3:0]  preIdx = '0;
  logic [31:0] preValue = '0;
  logic [3:0]  obsAddrIdx = '0;
  logic [31:0] obsAddrVal;
  logic [3:0]  obsDataIdx = '0;
  logic [31:0] obsDataVal;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] refA [16];
  logic [31:0] refD [16];

  always #5 clk = ~clk;

  sidx_agu dut_i (.*);

  function automatic logic [31:0] mkWord(logic [7:0] pri, logic [7:0] sub, logic [3:0] dst,
                                         logic [3:0] base, logic [3:0] idx, logic [1:0] n);
    return {dst, sub, 2'b00, n, base, idx, pri};
  endfunction

  function automatic logic [31:0] scaledRef(logic [31:0] b, logic [31:0] d, logic [1:0] n);
    return b + (d << n);
  endfunction

  function automatic logic [31:0] bitRef(logic [31:0] b, logic [31:0] d);
    logic [31:0] off;
    off = {{3{d[31]}}, d[31:3]};
    return (b + off) & 32'hFFFF_FFFC;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readA(logic [3:0] idx, output logic [31:0] v);
    obsAddrIdx = idx; #1; v = obsAddrVal;
  endtask

  task automatic readD(logic [3:0] idx, output logic [31:0] v);
    obsDataIdx = idx; #1; v = obsDataVal;
  endtask

  task automatic preA(logic [3:0] idx, logic [31:0] v);
    preAddrWe = 1; preIdx = idx; preValue = v;
    @(negedge clk); preAddrWe = 0;
    refA[idx] = v;
  endtask

  task automatic preD(logic [3:0] idx, logic [31:0] v);
    preDataWe = 1; preIdx = idx; preValue = v;
    @(negedge clk); preDataWe = 0;
    refD[idx] = v;
  endtask

  // model of one operation; returns legality, destination and value
  task automatic model(logic sf, logic [31:0] w, logic [3:0] sd, logic [3:0] sb, logic [1:0] sn,
                       output bit legal, output logic [3:0] dst, output logic [31:0] val);
    if (sf) begin
      legal = 1; dst = sd; val = scaledRef(refA[sb], refD[15], sn);
    end else begin
      dst = w[31:28];
      legal = (w[7:0] == 8'h01) && (w[27:20] == 8'h60 || w[27:20] == 8'h62);
      if (w[27:20] == 8'h62) val = bitRef(refA[w[15:12]], refD[w[11:8]]);
      else                   val = scaledRef(refA[w[15:12]], refD[w[11:8]], w[17:16]);
    end
  endtask

  task automatic issue(string tag, logic sf, logic [31:0] w, logic [3:0] sd, logic [3:0] sb,
                       logic [1:0] sn);
    bit legal; logic [3:0] dst; logic [31:0] val; logic [31:0] got;
    model(sf, w, sd, sb, sn, legal, dst, val);
    instValid = 1; shortForm = sf; instWord = w;
    shortDst = sd; shortBase = sb; shortShift = sn;
    @(negedge clk);
    instValid = 0;
    if (legal) refA[dst] = val;
    check({tag, " illegal flag"}, {31'b0, illegal}, {31'b0, !legal});
    readA(dst, got);
    check({tag, " dest value"}, got, refA[dst]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin refA[i] = '0; refD[i] = '0; end
    // dirty files before reset, then reset clears (R9)
    rst = 0;
    @(negedge clk);
    preA(4'd6, 32'hAAAA_5555);
    preD(4'd6, 32'h1234_5678);
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    for (int i = 0; i < 16; i++) begin refA[i] = '0; refD[i] = '0; end
    readA(4'd6, v); check("R9 addr reg cleared", v, 32'h0);
    readD(4'd6, v); check("R9 data reg cleared", v, 32'h0);
    check("R9 illegal cleared", {31'b0, illegal}, 32'h0);

    // R1 directed
    preA(4'd4, 32'h0000_1000);
    preD(4'd2, 32'h0000_0005);
    issue("R1 scaled n=2", 0, mkWord(8'h01, 8'h60, 4'd3, 4'd4, 4'd2, 2'd2), 0, 0, 0);
    readA(4'd3, v); check("R1 scaled sum", v, 32'h0000_1014);

    // R2 negative bit index, n field set but ignored
    preD(4'd2, 32'hFFFF_FFFF);
    issue("R2 bit mode", 0, mkWord(8'h01, 8'h62, 4'd3, 4'd4, 4'd2, 2'd3), 0, 0, 0);
    readA(4'd3, v); check("R2 word address", v, 32'h0000_0FFC);
    preD(4'd2, 32'h0000_0107);
    issue("R2 positive", 0, mkWord(8'h01, 8'h62, 4'd8, 4'd4, 4'd2, 2'd1), 0, 0, 0);
    readA(4'd8, v); check("R2 positive index", v, 32'h0000_1020);

    // R5 wrap
    preA(4'd9, 32'hFFFF_FFF0);
    preD(4'd1, 32'h0000_0010);
    issue("R5 wrap", 0, mkWord(8'h01, 8'h60, 4'd10, 4'd9, 4'd1, 2'd0), 0, 0, 0);
    readA(4'd10, v); check("R5 wrapped sum", v, 32'h0);

    // R3/R6 illegal words: bad primary, bad secondary
    preA(4'd11, 32'h0BAD_0BAD);
    issue("R3 bad primary", 0, mkWord(8'h02, 8'h60, 4'd11, 4'd4, 4'd2, 2'd0), 0, 0, 0);
    @(negedge clk);
    check("R6 illegal one cycle", {31'b0, illegal}, 32'h0);
    issue("R3 bad secondary", 0, mkWord(8'h01, 8'h61, 4'd11, 4'd4, 4'd2, 2'd0), 0, 0, 0);
    readA(4'd11, v); check("R6 no writeback", v, 32'h0BAD_0BAD);

    // R4 short form, word is garbage
    preD(4'd15, 32'h0000_0003);
    preA(4'd5, 32'h0000_0100);
    issue("R4 short", 1, 32'hFFFF_FFFF, 4'd7, 4'd5, 2'd3);
    readA(4'd7, v); check("R4 short sum", v, 32'h0000_0118);

    // R7 strobe low: nothing happens
    instWord = mkWord(8'h01, 8'h60, 4'd7, 4'd5, 4'd15, 2'd0);
    @(negedge clk);
    readA(4'd7, v); check("R7 no strobe no write", v, 32'h0000_0118);
    check("R7 no strobe no illegal", {31'b0, illegal}, 32'h0);

    // R8 back-to-back chain through A12
    preA(4'd12, 32'h0000_2000);
    issue("R8 first", 0, mkWord(8'h01, 8'h60, 4'd12, 4'd12, 4'd15, 2'd1), 0, 0, 0);
    issue("R8 second", 0, mkWord(8'h01, 8'h60, 4'd13, 4'd12, 4'd15, 2'd2), 0, 0, 0);
    readA(4'd13, v); check("R8 chained", v, 32'h0000_2012);

    // R10 collision: long form and short form against a preload
    preAddrWe = 1; preIdx = 4'd3; preValue = 32'hDEAD_BEEF;
    issue("R10 long collide", 0, mkWord(8'h01, 8'h60, 4'd3, 4'd5, 4'd15, 2'd0), 0, 0, 0);
    preAddrWe = 1; preIdx = 4'd7; preValue = 32'hDEAD_BEEF;
    issue("R10 short collide", 1, 32'h0, 4'd7, 4'd5, 2'd0);
    preAddrWe = 0;
    readA(4'd3, v); check("R10 instruction wins", v, 32'h0000_0103);

    // random mix
    for (int i = 0; i < 16; i++) begin
      preA(4'(i), $urandom);
      preD(4'(i), $urandom);
    end
    for (int k = 0; k < 300; k++) begin
      logic [7:0] pri; logic [7:0] sub; int r;
      r = $urandom % 10;
      pri = (r == 0) ? 8'($urandom) : 8'h01;
      sub = (r == 1) ? 8'($urandom) : (($urandom % 2) ? 8'h60 : 8'h62);
      if (r == 2)
        issue("R4 random short", 1, $urandom, 4'($urandom), 4'($urandom), 2'($urandom));
      else
        issue("R1 R2 random", 0, mkWord(pri, sub, 4'($urandom), 4'($urandom), 4'($urandom),
                                        2'($urandom)), 0, 0, 0);
      if (k % 50 == 0) preD(4'($urandom), $urandom);
    end

    // R11 data file untouched by instructions
    for (int i = 0; i < 16; i++) begin
      readD(4'(i), v); check("R11 data file intact", v, refD[i]);
      readA(4'(i), v); check("R1 address file final", v, refA[i]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule